// File: doc/BRIEF.md
# Predicated Narrowing Vector Store

This block writes the elements of one vector register to memory, one element per write, under a byte-granular predicate. A command gives a base address, a 5-bit register index, an element size, a memory access size and a vector length. The block selects the register through a read port into a register file that sits outside it. It then walks the elements from the lowest upward and issues sized write requests on a valid/ready port. It pulses `done` once the last element has been handled.

The memory access size may be smaller than the element size. In that case only the low-order part of each element is stored. The destination address advances by the access size for every element, whether or not that element is written. The result is a densely packed, narrowed copy of the vector in which masked elements leave gaps.

Top module: `narrow_vstore`

## Requirements
- R1: After reset, and whenever idle, `cmd_ready` is 1, and `mem_valid` and `done` are 0.
- R2: Elements are handled in ascending order starting from element 0. Accepted writes therefore appear with increasing element numbers.
- R3: An element is active exactly when the predicate bit at its lowest byte (bit index = element number × element bytes) is 1. The other predicate bits that cover the element have no effect.
- R4: An inactive element produces no write request.
- R5: Element e is stored at base + e × (memory bytes), modulo 2^AW. The address therefore advances by the access size for every element, active or not.
- R6: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. `mem_size` carries the command's memory size code. `mem_data` holds the low-order memory-size bytes of the element, right-aligned, with all higher bits 0.
- R7: Element e with element code s occupies register bytes e×2^s upward, little-endian (register byte b is `rf_data[8b+7:8b]`).
- R8: While `mem_valid` is 1 and `mem_ready` is 0, the request stays up with `mem_addr`, `mem_size` and `mem_data` unchanged. The next element is not examined until the write is accepted.
- R9: `done` is 1 for exactly one cycle, the cycle after the final element is handled, and `cmd_ready` is 1 in the following cycle. With `mem_ready` held at 1, `done` appears in the (vlen/E + 1)-th cycle after the accepting edge.
- R10: A command presented while the block is busy is ignored. It causes no writes, and it does not change the address, data or count of the running store.
- R11: From the accepting edge until the next command, `rf_sel` equals the command's register index.
- R12: Exactly vlen/E elements are processed, where vlen is a multiple of 16 bytes. Predicate bits at or above vlen are ignored. The predicate is consumed in 16-bit slices, one per 16-byte chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_addr | input | AW | Base address |
| cmd_reg | input | 5 | Source register index |
| cmd_esz | input | 2 | Element size code (0..3 = 1..8 bytes) |
| cmd_msz | input | 2 | Memory access size code, not larger than cmd_esz |
| cmd_vlen | input | $clog2(VB)+1 | Vector length in bytes, multiple of 16 |
| cmd_pred | input | VB | Predicate, one bit per vector byte |
| rf_sel | output | 5 | Register file read index |
| rf_data | input | 8*VB | Selected register contents |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Write request accepted |
| mem_addr | output | AW | Write byte address |
| mem_size | output | 2 | Write size code |
| mem_data | output | 64 | Write data, right-aligned |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches every cycle for a stalled request that drops or changes, for data bits above the access size, for a done pulse longer than one cycle or not followed by idle, for any write or done while idle, and for a register index that moves during a store. Which elements are written, their addresses and data, the narrowing from each element size, and the length cut-off can only be shown by the bench's scenarios. The same holds for the done latency and for ignoring a command sent mid-store: the bench compares each store's full write stream against a model built from the requirements.

// File: rtl/nvst_pkg.sv
package nvst_pkg;
   localparam int DW = 64;

   typedef enum logic [1:0] {
      SZ_B = 2'd0,
      SZ_H = 2'd1,
      SZ_W = 2'd2,
      SZ_D = 2'd3
   } nvst_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } nvst_state_e;
endpackage

// File: rtl/nvst_pred_pick.sv
module nvst_pred_pick
   import nvst_pkg::*;
#(
   parameter int VB = 32,
   parameter int IW = $clog2(VB) + 1
) (
   input  logic [VB-1:0] pred,
   input  logic [IW-1:0] idx,
   output logic          active
);
   localparam int NS = VB / 16;

   logic [15:0] slice [NS];
   logic [15:0] cur_slice;
   logic        in_range;

   for (genvar g = 0; g < NS; g++) begin : g_slice
      assign slice[g] = pred[g*16 +: 16];
   end

   if (NS == 1) begin : g_one
      assign cur_slice = slice[0];
   end else begin : g_many
      localparam int SW = $clog2(NS);
      assign cur_slice = slice[idx[3+SW:4]];
   end

   assign in_range = idx < IW'(VB);
   assign active   = in_range && cur_slice[idx[3:0]];
endmodule

// File: rtl/nvst_elem_pick.sv
module nvst_elem_pick
   import nvst_pkg::*;
#(
   parameter int VB = 32,
   parameter int IW = $clog2(VB) + 1
) (
   input  logic [VB*8-1:0] vec,
   input  logic [IW-1:0]   idx,
   input  nvst_size_e      msz,
   output logic [DW-1:0]   data
);
   localparam int PW = VB * 8 + DW;

   logic [PW-1:0] padded;
   logic [DW-1:0] raw;
   logic [DW-1:0] keep;

   assign padded = {{DW{1'b0}}, vec};
   assign raw    = DW'(padded >> {idx, 3'b000});

   always_comb begin
      unique case (msz)
         SZ_B:    keep = DW'({8{1'b1}});
         SZ_H:    keep = DW'({16{1'b1}});
         SZ_W:    keep = DW'({32{1'b1}});
         default: keep = {DW{1'b1}};
      endcase
   end

   assign data = raw & keep;
endmodule

// File: rtl/nvst_walker.sv
module nvst_walker
   import nvst_pkg::*;
#(
   parameter int AW = 32,
   parameter int IW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [AW-1:0] base,
   input  nvst_size_e    esz,
   input  nvst_size_e    msz,
   input  logic [IW-1:0] vlen,
   output logic [IW-1:0] idx,
   output logic [AW-1:0] addr,
   output logic          last
);
   logic [IW:0] idx_nxt;

   assign idx_nxt = {1'b0, idx} + ((IW+1)'(1) << esz);
   assign last    = idx_nxt >= {1'b0, vlen};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx  <= '0;
         addr <= '0;
      end else if (load) begin
         idx  <= '0;
         addr <= base;
      end else if (step) begin
         idx  <= idx_nxt[IW-1:0];
         addr <= addr + (AW'(1) << msz);
      end
   end
endmodule

// File: rtl/narrow_vstore.sv
module narrow_vstore
   import nvst_pkg::*;
#(
   parameter int AW = 32,
   parameter int VB = 32,
   localparam int IW = $clog2(VB) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [AW-1:0]     cmd_addr,
   input  logic [4:0]        cmd_reg,
   input  logic [1:0]        cmd_esz,
   input  logic [1:0]        cmd_msz,
   input  logic [IW-1:0]     cmd_vlen,
   input  logic [VB-1:0]     cmd_pred,
   output logic [4:0]        rf_sel,
   input  logic [VB*8-1:0]   rf_data,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [AW-1:0]     mem_addr,
   output logic [1:0]        mem_size,
   output logic [DW-1:0]     mem_data,
   output logic              done
);
   if (VB < 16 || VB % 16 != 0) begin : g_bad_vb
      $error("narrow_vstore: VB must be a positive multiple of 16");
   end
   if (AW < 8) begin : g_bad_aw
      $error("narrow_vstore: AW too small");
   end

   nvst_state_e   state_q;
   nvst_size_e    esz_q, msz_q;
   logic [IW-1:0] vlen_q;
   logic [VB-1:0] pred_q;
   logic [4:0]    reg_q;

   logic          accept, active, advance, last;
   logic [IW-1:0] idx;

   assign cmd_ready = (state_q == ST_IDLE);
   assign accept    = cmd_ready && cmd_valid;
   assign advance   = (state_q == ST_RUN) && (!active || mem_ready);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         esz_q   <= SZ_B;
         msz_q   <= SZ_B;
         vlen_q  <= '0;
         pred_q  <= '0;
         reg_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               state_q <= ST_RUN;
               esz_q   <= nvst_size_e'(cmd_esz);
               msz_q   <= nvst_size_e'(cmd_msz);
               vlen_q  <= cmd_vlen;
               pred_q  <= cmd_pred;
               reg_q   <= cmd_reg;
            end
            ST_RUN:  if (advance && last) state_q <= ST_DONE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   nvst_walker #(.AW(AW), .IW(IW)) u_walk (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .step  (advance && !last),
      .base  (cmd_addr),
      .esz   (esz_q),
      .msz   (msz_q),
      .vlen  (vlen_q),
      .idx   (idx),
      .addr  (mem_addr),
      .last  (last)
   );

   nvst_pred_pick #(.VB(VB), .IW(IW)) u_pred (
      .pred   (pred_q),
      .idx    (idx),
      .active (active)
   );

   nvst_elem_pick #(.VB(VB), .IW(IW)) u_elem (
      .vec  (rf_data),
      .idx  (idx),
      .msz  (msz_q),
      .data (mem_data)
   );

   assign rf_sel    = reg_q;
   assign mem_valid = (state_q == ST_RUN) && active;
   assign mem_size  = msz_q;
   assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/nvst_chk.sv
module nvst_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_ready,
   input logic [4:0]    rf_sel,
   input logic          mem_valid,
   input logic          mem_ready,
   input logic [AW-1:0] mem_addr,
   input logic [1:0]    mem_size,
   input logic [63:0]   mem_data,
   input logic          done
);
   a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                 && $stable(mem_size) && $stable(mem_data));

   a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_data >> (7'd8 << mem_size)) == 64'd0);

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && cmd_ready);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !mem_valid && !done);

   a_r11_sel_steady: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_ready && !$past(cmd_ready) |-> $stable(rf_sel));
endmodule

bind narrow_vstore nvst_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_ready (cmd_ready),
   .rf_sel    (rf_sel),
   .mem_valid (mem_valid),
   .mem_ready (mem_ready),
   .mem_addr  (mem_addr),
   .mem_size  (mem_size),
   .mem_data  (mem_data),
   .done      (done)
);

// File: tb/sim_narrow_vstore.sv
module sim_narrow_vstore;
   localparam int AW = 32;
   localparam int VB = 32;
   localparam int IW = $clog2(VB) + 1;

   typedef struct packed {
      logic [31:0]   addr;
      logic [4:0]    rsel;
      logic [1:0]    esz;
      logic [1:0]    msz;
      logic [IW-1:0] vlen;
      logic [31:0]   pred;
      logic          stall;
      logic [7:0]    nexp;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      '{32'h0000_0100,  5'd0, 2'd0, 2'd0, 6'd32, 32'hFFFF_FFFF, 1'b0, 8'd32},
      '{32'h0000_2000,  5'd5, 2'd1, 2'd0, 6'd32, 32'h5555_5555, 1'b0, 8'd16},
      '{32'h0000_3000,  5'd6, 2'd1, 2'd0, 6'd32, 32'hAAAA_AAAA, 1'b0, 8'd0},
      '{32'h0000_4001,  5'd9, 2'd2, 2'd1, 6'd16, 32'hFFFF_0101, 1'b0, 8'd2},
      '{32'h0000_5000, 5'd12, 2'd3, 2'd0, 6'd32, 32'h0100_0001, 1'b0, 8'd2},
      '{32'h0000_6000, 5'd31, 2'd3, 2'd2, 6'd32, 32'hFFFF_FFFF, 1'b1, 8'd4},
      '{32'h0000_7008, 5'd17, 2'd3, 2'd3, 6'd32, 32'h0001_0100, 1'b1, 8'd2},
      '{32'hFFFF_FFF0, 5'd20, 2'd2, 2'd2, 6'd32, 32'h1000_0010, 1'b1, 8'd2},
      '{32'h0000_8000,  5'd2, 2'd0, 2'd0, 6'd16, 32'hFFFF_0000, 1'b0, 8'd0},
      '{32'h0000_9000,  5'd1, 2'd2, 2'd0, 6'd32, 32'hFFFF_FFFF, 1'b1, 8'd8}
   };

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            cmd_valid = 1'b0;
   logic            cmd_ready;
   logic [AW-1:0]   cmd_addr = '0;
   logic [4:0]      cmd_reg = '0;
   logic [1:0]      cmd_esz = '0;
   logic [1:0]      cmd_msz = '0;
   logic [IW-1:0]   cmd_vlen = '0;
   logic [VB-1:0]   cmd_pred = '0;
   logic [4:0]      rf_sel;
   logic [VB*8-1:0] rf_data;
   logic            mem_valid;
   logic            mem_ready = 1'b1;
   logic [AW-1:0]   mem_addr;
   logic [1:0]      mem_size;
   logic [63:0]     mem_data;
   logic            done;

   narrow_vstore #(.AW(AW), .VB(VB)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_addr(cmd_addr), .cmd_reg(cmd_reg), .cmd_esz(cmd_esz), .cmd_msz(cmd_msz),
      .cmd_vlen(cmd_vlen), .cmd_pred(cmd_pred), .rf_sel(rf_sel), .rf_data(rf_data),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
      .mem_size(mem_size), .mem_data(mem_data), .done(done)
   );

   function automatic logic [7:0] rf_byte(input int r, input int b);
      return 8'((r * 37 + b * 11 + 5) & 255);
   endfunction

   always_comb begin
      for (int b = 0; b < VB; b++) rf_data[b*8 +: 8] = rf_byte(int'(rf_sel), b);
   end

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   logic          stall = 1'b0;
   int            cyc = 0;
   always @(posedge clk) begin
      #1;
      cyc++;
      mem_ready = stall ? (cyc % 3 == 0) : 1'b1;
   end

   logic [AW-1:0] got_addr [64];
   logic [1:0]    got_size [64];
   logic [63:0]   got_data [64];
   int            got_n = 0;
   logic          hold_pend = 1'b0;
   logic [AW-1:0] hold_addr;
   logic [1:0]    hold_size;
   logic [63:0]   hold_data;

   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_pend)
            chk(mem_valid && mem_addr == hold_addr && mem_size == hold_size &&
                mem_data == hold_data, "R8 stalled request held",
                {mem_valid, mem_addr}, {1'b1, hold_addr});
         hold_pend = mem_valid && !mem_ready;
         hold_addr = mem_addr;
         hold_size = mem_size;
         hold_data = mem_data;
         if (mem_valid && mem_ready && got_n < 64) begin
            got_addr[got_n] = mem_addr;
            got_size[got_n] = mem_size;
            got_data[got_n] = mem_data;
            got_n++;
         end
      end
   end

   task automatic summary_and_end();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary_and_end();
   end

   task automatic issue(input vec_t v);
      @(posedge clk); #1;
      cmd_valid = 1'b1;
      cmd_addr  = v.addr;
      cmd_reg   = v.rsel;
      cmd_esz   = v.esz;
      cmd_msz   = v.msz;
      cmd_vlen  = v.vlen;
      cmd_pred  = v.pred;
      got_n     = 0;
      @(posedge clk); #1;
      cmd_valid = 1'b0;
   endtask

   task automatic wait_done(output int at);
      at = -1;
      for (int n = 1; n < 1000; n++) begin
         @(negedge clk);
         if (done) begin
            at = n;
            break;
         end
      end
   endtask

   // compare the write stream against the model built from R2..R7, R12
   task automatic verify_stream(input vec_t v, input string tag);
      int nel, k;
      nel = int'(v.vlen) >> v.esz;
      k = 0;
      for (int e = 0; e < nel; e++) begin
         int bi;
         logic [63:0] ed;
         logic [AW-1:0] ea;
         bi = e << v.esz;
         if (v.pred[bi]) begin
            ed = '0;
            for (int j = 0; j < (1 << v.msz); j++) ed[j*8 +: 8] = rf_byte(int'(v.rsel), bi + j);
            ea = v.addr + AW'(e << v.msz);
            if (k < got_n) begin
               chk(got_addr[k] == ea, {tag, " R5 R2 address"}, 64'(got_addr[k]), 64'(ea));
               chk(got_size[k] == v.msz, {tag, " R6 size code"}, 64'(got_size[k]), 64'(v.msz));
               chk(got_data[k] == ed, {tag, " R6 R7 data"}, got_data[k], ed);
            end
            k++;
         end
      end
      chk(got_n == k, {tag, " R3 R4 R12 write count"}, 64'(got_n), 64'(k));
      chk(k == int'(v.nexp), {tag, " R3 table count"}, 64'(k), 64'(v.nexp));
   endtask

   initial begin
      int at;
      vec_t bv;
      // R1: reset state
      repeat (2) @(negedge clk);
      chk(cmd_ready && !mem_valid && !done, "R1 during reset",
          {cmd_ready, mem_valid, done}, 3'b100);
      @(posedge clk); #1; rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready && !mem_valid && !done, "R1 after reset",
          {cmd_ready, mem_valid, done}, 3'b100);

      for (int t = 0; t < NV; t++) begin
         stall = TBL[t].stall;
         issue(TBL[t]);
         wait_done(at);
         chk(at > 0, "R9 done seen", 64'(at), 64'd1);
         if (!TBL[t].stall)
            chk(at == (int'(TBL[t].vlen) >> TBL[t].esz) + 1, "R9 done latency",
                64'(at), 64'((int'(TBL[t].vlen) >> TBL[t].esz) + 1));
         chk(rf_sel == TBL[t].rsel, "R11 register index", 64'(rf_sel), 64'(TBL[t].rsel));
         @(negedge clk);
         chk(!done && cmd_ready, "R9 single pulse then idle", {done, cmd_ready}, 2'b01);
         verify_stream(TBL[t], $sformatf("vec%0d", t));
      end

      // R10: a command offered mid-store is ignored
      bv = '{32'h0000_1000, 5'd3, 2'd0, 2'd0, 6'd16, 32'h0000_FFFF, 1'b1, 8'd16};
      stall = 1'b1;
      issue(bv);
      repeat (3) @(posedge clk);
      #1;
      cmd_valid = 1'b1;
      cmd_addr  = 32'h0000_9000;
      cmd_reg   = 5'd7;
      cmd_esz   = 2'd3;
      cmd_msz   = 2'd3;
      repeat (2) @(posedge clk);
      #1;
      cmd_valid = 1'b0;
      chk(rf_sel == 5'd3, "R10 R11 index kept while busy", 64'(rf_sel), 64'd3);
      wait_done(at);
      verify_stream(bv, "busy");
      repeat (6) @(negedge clk);
      chk(got_n == 16, "R10 no extra writes afterwards", 64'(got_n), 64'd16);
      chk(cmd_ready && !mem_valid, "R10 R1 idle after ignored command",
          {cmd_ready, mem_valid}, 2'b10);

      summary_and_end();
   end
endmodule